// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A single-port synchronous static RAM with a registered control front end, a pipelined read path and a late write. Reads and writes can alternate on every clock edge with no idle bus cycles. The data for a write is taken from the data bus two rising edges after its address. A read's data appears on the bus after the next rising edge, so both directions use the same bus slot relative to their address cycle.

The address, chip enable, write strobe, advance control and byte write enables are captured on the rising clock edge. The burst order select and the output enable are not registered. An advance cycle continues the last operation through a 2-bit wrapping burst counter, in either linear or interleaved order.

A read that hits a write whose data has not yet reached the array returns that pending data, merged per byte lane. The word width is a parameter: 36 bits in four 9-bit lanes, or 18 bits in two lanes.

Top module: `zbt_sram`

## Requirements
- R1: While rst_ni is low, dq_oe_o is 0 and dq_o is all zeros.
- R2: A read sampled at rising edge n (ce_i=1, we_i=0, adv_i=0) puts the word on dq_o with dq_oe_o=1 (oe_i=1) after edge n+1, for exactly that one cycle.
- R3: A write sampled at edge n takes its data from dq_i at edge n+2. Reads and writes may alternate on consecutive edges with no idle cycle.
- R4: bw_i bit k enables byte lane k, which is data bits 9k+8 down to 9k. Lanes whose bit is 0 keep their old contents.
- R5: A read of an address whose write has been sampled but not yet committed returns the pending data in the enabled lanes and the array data in the other lanes.
- R6: A deselect (ce_i=0, adv_i=0) sampled at edge n leaves the drive of the read from edge n-1 in place after edge n, and turns dq_oe_o off after edge n+1.
- R7: dq_oe_o is 0 whenever oe_i is 0. oe_i has no effect on dq_o or on later operations.
- R8: When adv_i=1 after an active operation, ce_i, we_i and addr_i are ignored. The operation repeats the previous direction on the next burst address. The upper address bits stay fixed. The low two bits are (start+count) mod 4 when lin_i=1, and start XOR count when lin_i=0, where count is 1, 2, 3 across the burst.
- R9: adv_i=1 sampled after a deselect keeps the block deselected, so no drive follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, registered |
| we_i | input | 1 | 1 = write, 0 = read, registered |
| adv_i | input | 1 | 1 = continue burst, 0 = load new operation |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved (static, unregistered) |
| addr_i | input | AW | Word address, registered |
| bw_i | input | W/9 | Byte-lane write enables, registered |
| oe_i | input | 1 | Asynchronous output enable |
| dq_i | input | W | Data bus, input half |
| dq_o | output | W | Data bus, output half |
| dq_oe_o | output | 1 | Data bus output drive enable |

## Verification
Faults in the pipeline show up at the ports within two edges of the operation that exposes them. A wrong stage register shifts read data or drive enable by a cycle. A wrong write stage stores the wrong bus slot, which a later read returns. A missing forward path returns stale lanes on the read that immediately follows a write to the same address. Burst counter or order errors produce a permuted data sequence during a read burst over known contents.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             we_i,
  input  logic             adv_i,
  input  logic             lin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_i,
  output logic             op_vld_o,
  output logic             op_we_o,
  output logic [AW-1:0]    op_addr_o,
  output logic [LANES-1:0] op_bw_o
);
  import zbt_pkg::*;

  logic                vld_q, we_q;
  logic [AW-1:0]       base_q;
  logic [BURST_W-1:0]  cnt_q, low;
  logic [LANES-1:0]    bw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      we_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      bw_q   <= '0;
    end else begin
      bw_q <= bw_i;
      if (adv_i) begin
        if (vld_q) cnt_q <= cnt_q + 1'b1;
      end else begin
        vld_q <= ce_i;
        we_q  <= we_i;
        cnt_q <= '0;
        if (ce_i) base_q <= addr_i;
      end
    end
  end

  // burst order is a static strap, applied after the register
  always_comb begin
    if (lin_i) low = base_q[BURST_W-1:0] + cnt_q;
    else       low = base_q[BURST_W-1:0] ^ cnt_q;
  end

  assign op_vld_o  = vld_q;
  assign op_we_o   = we_q;
  assign op_addr_o = {base_q[AW-1:BURST_W], low};
  assign op_bw_o   = bw_q;

  // R8
  burst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && vld_q) |=> (vld_q && $stable(we_q) && $stable(op_addr_o[AW-1:BURST_W])));

  // R9
  adv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !vld_q) |=> !vld_q);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic                               clk_i,
  input  logic                               wr_en_i,
  input  logic [AW-1:0]                      wr_addr_i,
  input  logic [LANES-1:0]                   wr_bw_i,
  input  logic [LANES*zbt_pkg::LANE_W-1:0]   wr_data_i,
  input  logic [AW-1:0]                      rd_addr_i,
  output logic [LANES*zbt_pkg::LANE_W-1:0]   rd_data_o
);
  import zbt_pkg::*;
  localparam int unsigned DEPTH = 2**AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_bw_i[l]) mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/zbt_rdpath.sv
module zbt_rdpath #(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             s1_vld_i,
  input  logic                             s1_we_i,
  input  logic [AW-1:0]                    s1_addr_i,
  input  logic [LANES-1:0]                 s1_bw_i,
  input  logic                             oe_i,
  input  logic [LANES*zbt_pkg::LANE_W-1:0] dq_i,
  output logic [LANES*zbt_pkg::LANE_W-1:0] dq_o,
  output logic                             dq_oe_o,
  output logic                             wr_en_o,
  output logic [AW-1:0]                    wr_addr_o,
  output logic [LANES-1:0]                 wr_bw_o,
  output logic [LANES*zbt_pkg::LANE_W-1:0] wr_data_o,
  output logic [AW-1:0]                    rd_addr_o,
  input  logic [LANES*zbt_pkg::LANE_W-1:0] rd_data_i
);
  import zbt_pkg::*;
  localparam int unsigned W = LANES * LANE_W;

  logic             s2_vld, s2_we;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_bw;
  logic [W-1:0]     fwd, dout_q;
  logic             drive_q, hit, rd_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_we   <= 1'b0;
      s2_addr <= '0;
      s2_bw   <= '0;
    end else begin
      s2_vld  <= s1_vld_i;
      s2_we   <= s1_we_i;
      s2_addr <= s1_addr_i;
      s2_bw   <= s1_bw_i;
    end
  end

  // late write: data on the bus now belongs to the op two edges back
  assign wr_en_o   = s2_vld && s2_we;
  assign wr_addr_o = s2_addr;
  assign wr_bw_o   = s2_bw;
  assign wr_data_o = dq_i;
  assign rd_addr_o = s1_addr_i;

  assign rd_now = s1_vld_i && !s1_we_i;
  assign hit    = wr_en_o && (s2_addr == s1_addr_i);

  // write committing at this edge is not yet visible in the array
  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd[l*LANE_W +: LANE_W] = (hit && s2_bw[l]) ? dq_i[l*LANE_W +: LANE_W]
                                                       : rd_data_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= rd_now;
      if (rd_now) dout_q <= fwd;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drive_q && oe_i;

  // R2
  rd_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_now |=> drive_q);

  // R6
  desel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld_i |=> !drive_q);

  // R3
  late_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_i && s1_we_i) |=> wr_en_o);

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_q |-> !dq_oe_o);
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter bit          WIDE_CFG = 1'b1,
  parameter int unsigned AW       = 8,
  localparam int unsigned W       = WIDE_CFG ? 36 : 18,
  localparam int unsigned LANES   = W / zbt_pkg::LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             we_i,
  input  logic             adv_i,
  input  logic             lin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_i,
  input  logic             oe_i,
  input  logic [W-1:0]     dq_i,
  output logic [W-1:0]     dq_o,
  output logic             dq_oe_o
);
  logic             s1_vld, s1_we, wr_en;
  logic [AW-1:0]    s1_addr, wr_addr, rd_addr;
  logic [LANES-1:0] s1_bw, wr_bw;
  logic [W-1:0]     wr_data, rd_data;

  zbt_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .ce_i, .we_i, .adv_i, .lin_i, .addr_i, .bw_i,
    .op_vld_o (s1_vld),
    .op_we_o  (s1_we),
    .op_addr_o(s1_addr),
    .op_bw_o  (s1_bw)
  );

  zbt_rdpath #(.AW(AW), .LANES(LANES)) u_rdpath (
    .clk_i, .rst_ni,
    .s1_vld_i (s1_vld),
    .s1_we_i  (s1_we),
    .s1_addr_i(s1_addr),
    .s1_bw_i  (s1_bw),
    .oe_i, .dq_i, .dq_o, .dq_oe_o,
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_bw_o  (wr_bw),
    .wr_data_o(wr_data),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  zbt_array #(.AW(AW), .LANES(LANES)) u_array (
    .clk_i,
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_bw_i  (wr_bw),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_i = 0, we_i = 0, adv_i = 0, lin_i = 1, oe_i = 1;
  logic [7:0]  addr_i = '0;
  logic [3:0]  bw_i = '0;
  logic [35:0] dq_i = '0;
  logic [35:0] dq_o;
  logic        dq_oe_o;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  zbt_sram u0 (.clk_i(clk), .rst_ni, .ce_i, .we_i, .adv_i, .lin_i, .addr_i,
               .bw_i, .oe_i, .dq_i, .dq_o, .dq_oe_o);

  typedef struct packed {
    logic ce, we, adv;
    logic [7:0]  addr;
    logic [3:0]  bw;
    logic [35:0] din;
    logic        exp_oe, chk_dq;
    logic [35:0] exp_dq;
    logic [3:0]  req;
  } vec_t;

  localparam logic [35:0] D1 = 36'hFFFFFFFFF, D2 = 36'h123456789,
                          D3 = 36'hFEDCBA987, D4 = 36'h000000000,
                          MIX = 36'hFF803FE00;  // lanes 1,3 from D1, lanes 0,2 from D4

  localparam vec_t TAB [13] = '{
    '{1,1,0,8'd1,4'hF,36'h0,0,0,36'h0,4'd1},  // R1 idle after reset
    '{1,1,0,8'd2,4'hF,36'h0,0,0,36'h0,4'd3},  // R3 back-to-back writes
    '{1,0,0,8'd1,4'hF,D1   ,0,0,36'h0,4'd3},  // R3 data for addr 1
    '{1,0,0,8'd2,4'hF,D2   ,1,1,D1   ,4'd2},  // R2 read addr 1
    '{1,1,0,8'd3,4'hF,36'h0,1,1,D2   ,4'd2},  // R2 read addr 2, write follows
    '{1,0,0,8'd3,4'hF,36'h0,0,0,36'h0,4'd3},  // R3 read right after write
    '{1,1,0,8'd1,4'h5,D3   ,1,1,D3   ,4'd5},  // R5 forwarded full word
    '{1,0,0,8'd1,4'hF,36'h0,0,0,36'h0,4'd4},  // R4 partial write pending
    '{0,0,0,8'd0,4'h0,D4   ,1,1,MIX  ,4'd5},  // R5 forwarded lane merge
    '{0,0,0,8'd0,4'h0,36'h0,0,0,36'h0,4'd6},  // R6 deselect drops drive
    '{1,0,0,8'd1,4'hF,36'h0,0,0,36'h0,4'd4},  // R4 reread from array
    '{0,0,0,8'd0,4'h0,36'h0,1,1,MIX  ,4'd4},  // R4 untouched lanes kept
    '{0,0,0,8'd0,4'h0,36'h0,0,0,36'h0,4'd6}   // R6 two-cycle deselect
  };

  task automatic chk_bit(string req, logic got, logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s dq_oe_o got %0b exp %0b", req, got, exp);
    end
  endtask

  task automatic chk_word(string req, logic [35:0] got, logic [35:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s dq_o got %h exp %h", req, got, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(logic ce, logic we, logic adv, logic [7:0] a, logic [3:0] bw, logic [35:0] d);
    ce_i = ce; we_i = we; adv_i = adv; addr_i = a; bw_i = bw; dq_i = d;
    @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_bit("R1", dq_oe_o, 1'b0);
    chk_word("R1", dq_o, 36'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < 13; k++) begin
      cyc(TAB[k].ce, TAB[k].we, TAB[k].adv, TAB[k].addr, TAB[k].bw, TAB[k].din);
      chk_bit($sformatf("R%0d vec %0d", TAB[k].req, k), dq_oe_o, TAB[k].exp_oe);
      if (TAB[k].chk_dq) chk_word($sformatf("R%0d vec %0d", TAB[k].req, k), dq_o, TAB[k].exp_dq);
    end

    // R8 linear write burst 4,5,6,7
    lin_i = 1'b1;
    cyc(1,1,0,8'd4,4'hF,36'h0);
    cyc(1,0,1,8'd99,4'hF,36'h0);
    cyc(0,0,1,8'd0,4'hF,36'h444444444);
    cyc(0,0,1,8'd0,4'hF,36'h555555555);
    cyc(0,0,0,8'd0,4'hF,36'h666666666);
    cyc(0,0,0,8'd0,4'hF,36'h777777777);
    cyc(0,0,0,8'd0,4'h0,36'h0);

    // R8 interleaved read burst from 5: 5,4,7,6
    lin_i = 1'b0;
    cyc(1,0,0,8'd5,4'h0,36'h0);
    chk_bit("R8", dq_oe_o, 1'b0);
    cyc(1,1,1,8'd0,4'h0,36'h0);
    chk_bit("R8", dq_oe_o, 1'b1);
    chk_word("R8", dq_o, 36'h555555555);
    cyc(0,0,1,8'd0,4'h0,36'h0);
    chk_word("R8", dq_o, 36'h444444444);
    oe_i = 1'b0;
    #1;
    chk_bit("R7", dq_oe_o, 1'b0);
    chk_word("R7", dq_o, 36'h444444444);
    oe_i = 1'b1;
    cyc(0,0,1,8'd0,4'h0,36'h0);
    chk_word("R8", dq_o, 36'h777777777);
    chk_bit("R7", dq_oe_o, 1'b1);
    cyc(0,0,0,8'd0,4'h0,36'h0);
    chk_word("R8", dq_o, 36'h666666666);
    chk_bit("R6", dq_oe_o, 1'b1);
    cyc(0,0,1,8'd0,4'h0,36'h0);
    chk_bit("R6", dq_oe_o, 1'b0);
    cyc(1,0,1,8'd5,4'h0,36'h0);
    chk_bit("R9", dq_oe_o, 1'b0);
    cyc(0,0,0,8'd0,4'h0,36'h0);
    chk_bit("R9", dq_oe_o, 1'b0);

    report();
    $finish;
  end
endmodule